// File: doc/BRIEF.md
# Multi-Mode Fixed-Point Integer Rounder

This block takes a signed-magnitude fixed-point number, an unsigned integer magnitude plus an unsigned binary fraction and a separate sign bit, and rounds it to a signed-magnitude integer. A 3-bit mode input picks the rounding rule on every sample: nearest with ties to even, nearest with ties toward the larger neighbour, truncation toward zero, rounding toward plus infinity, or rounding toward minus infinity.

Besides the rounded sign and magnitude, the block reports whether any fraction was discarded (inexact) and whether the increment carried out of the integer field (overflow). The rounding logic is purely combinational. A parameter adds a single output register stage, which is enabled by default. It is meant to sit at the tail of a fixed-point or conversion datapath, with the mode driven from a control field.

Top module: `fxr_round_top`

## Requirements
- R1: Mode code 000 rounds to nearest, and an exact tie goes to the neighbour with an even magnitude. For example, +3.5 and +4.5 both give 4, and -2.5 gives -2.
- R2: In modes 000 and 001, a fraction below one half truncates the magnitude, and a fraction above one half increments it. The fraction is FRAC_W bits wide and its MSB weighs 1/2.
- R3: Mode code 001 rounds to nearest, and an exact tie goes to the larger neighbour. For example, +2.5 gives +3 and -2.5 gives -2.
- R4: Mode code 010 truncates the magnitude for either sign.
- R5: Mode code 011 increments the magnitude for a positive input with a nonzero fraction, and truncates a negative one.
- R6: Mode code 100 increments the magnitude for a negative input with a nonzero fraction, and truncates a positive one.
- R7: Mode codes 101, 110 and 111 give the same result as code 000.
- R8: The inexact flag is 1 exactly when the input fraction is nonzero. Without an increment, the magnitude equals the input integer part.
- R9: When an increment carries out of the INT_W-bit integer field, the overflow flag is 1 and the magnitude reads 0. The overflow flag is 0 otherwise.
- R10: The output sign always equals the input sign, including a zero magnitude. For example, -0.375 toward zero gives sign 1 and magnitude 0.
- R11: With REG_OUT=1, the outputs reflect the inputs sampled at the previous rising clock edge. An active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Input sign, 1 for negative |
| int_i | input | INT_W | Integer part of the magnitude |
| frac_i | input | FRAC_W | Fraction part of the magnitude |
| mode_i | input | 3 | Rounding mode code |
| sign_o | output | 1 | Result sign |
| mag_o | output | INT_W | Result magnitude |
| inexact_o | output | 1 | Fraction was discarded |
| ovf_o | output | 1 | Increment carried out of the integer field |

## Verification
A wrong increment decision appears in mag_o one clock after the offending input, as a magnitude that is off by one. A tie-handling fault shows only for a fraction of exactly one half, and depends on the sign or on the parity of the integer part. A dropped carry shows at the all-ones integer value, as a missing overflow flag and a nonzero magnitude. A sign fault is visible even at zero magnitude, so it surfaces in the same cycle as any rounding error.

// File: rtl/fxr_round_pkg.sv
package fxr_round_pkg;
    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'b000,
        RM_NEAR_UP   = 3'b001,
        RM_ZERO      = 3'b010,
        RM_POS_INF   = 3'b011,
        RM_NEG_INF   = 3'b100
    } rnd_mode_e;
endpackage

// File: rtl/fxr_round_decide.sv
module fxr_round_decide
    import fxr_round_pkg::*;
#(
    parameter int FRAC_W = 3
) (
    input  logic              sign_i,
    input  logic              lsb_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [2:0]        mode_i,
    output logic              inc_o,
    output logic              inexact_o
);
    logic half_bit;
    logic sticky;
    logic nonzero;

    assign half_bit = frac_i[FRAC_W-1];
    assign nonzero  = |frac_i;

    generate
        if (FRAC_W > 1) begin : g_sticky
            assign sticky = |frac_i[FRAC_W-2:0];
        end else begin : g_nosticky
            assign sticky = 1'b0;
        end
    endgenerate

    always_comb begin
        case (rnd_mode_e'(mode_i))
            RM_NEAR_UP: begin
                // positive tie goes up in magnitude, negative tie toward zero
                if (sign_i) inc_o = half_bit & sticky;
                else        inc_o = half_bit;
            end
            RM_ZERO:    inc_o = 1'b0;
            RM_POS_INF: inc_o = nonzero & ~sign_i;
            RM_NEG_INF: inc_o = nonzero & sign_i;
            default:    inc_o = half_bit & (sticky | lsb_i);
        endcase
    end

    assign inexact_o = nonzero;

    // R8: no increment ever happens on an exact input
    always_comb begin
        if (!$isunknown({frac_i, mode_i, sign_i, lsb_i})) begin
            a_exact_no_inc_r8: assert (nonzero || !inc_o);
        end
    end
endmodule

// File: rtl/fxr_round_incr.sv
module fxr_round_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] mag_i,
    input  logic         inc_i,
    output logic [W-1:0] mag_o,
    output logic         carry_o
);
    logic [W:0] sum;

    assign sum     = {1'b0, mag_i} + {{W{1'b0}}, inc_i};
    assign mag_o   = sum[W-1:0];
    assign carry_o = sum[W];

    // R9: a carry leaves an all-zero magnitude
    always_comb begin
        if (!$isunknown({mag_i, inc_i})) begin
            a_carry_zero_r9: assert (!carry_o || (mag_o == '0));
        end
    end
endmodule

// File: rtl/fxr_round_top.sv
module fxr_round_top
    import fxr_round_pkg::*;
#(
    parameter int INT_W   = 4,
    parameter int FRAC_W  = 3,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sign_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [2:0]        mode_i,
    output logic              sign_o,
    output logic [INT_W-1:0]  mag_o,
    output logic              inexact_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic             sign;
        logic [INT_W-1:0] mag;
        logic             inexact;
        logic             ovf;
    } res_t;

    res_t res_d, res_q;

    logic             inc;
    logic             inexact;
    logic [INT_W-1:0] mag_sum;
    logic             carry;

    fxr_round_decide #(.FRAC_W(FRAC_W)) u_decide (
        .sign_i    (sign_i),
        .lsb_i     (int_i[0]),
        .frac_i    (frac_i),
        .mode_i    (mode_i),
        .inc_o     (inc),
        .inexact_o (inexact)
    );

    fxr_round_incr #(.W(INT_W)) u_incr (
        .mag_i   (int_i),
        .inc_i   (inc),
        .mag_o   (mag_sum),
        .carry_o (carry)
    );

    always_comb begin
        res_d         = '0;
        res_d.sign    = sign_i;
        res_d.mag     = mag_sum;
        res_d.inexact = inexact;
        res_d.ovf     = carry;
    end

    generate
        if (REG_OUT) begin : g_reg
            logic live_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q  <= '0;
                    live_q <= 1'b0;
                end else begin
                    res_q  <= res_d;
                    live_q <= 1'b1;
                end
            end

            p_sign_kept_r10: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                sign_o == $past(sign_i));
            p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                ovf_o |-> (mag_o == '0) && ($past(int_i) == '1));
            p_trunc_zero_r4: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                ($past(mode_i) == 3'b010) |-> (mag_o == $past(int_i)) && !ovf_o);
            p_exact_pass_r8: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                ($past(frac_i) == '0) |-> !inexact_o && (mag_o == $past(int_i)));
            p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                !ovf_o |-> ((mag_o - $past(int_i)) <= 1));
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign sign_o    = res_q.sign;
    assign mag_o     = res_q.mag;
    assign inexact_o = res_q.inexact;
    assign ovf_o     = res_q.ovf;
endmodule

// File: tb/fxr_round_top_test.sv
module fxr_round_top_test;
    localparam int CLK_P  = 10;
    localparam int INT_W  = 4;
    localparam int FRAC_W = 3;
    localparam int HALF   = 1 << (FRAC_W - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sign_i = 1'b0;
    logic [INT_W-1:0]  int_i = '0;
    logic [FRAC_W-1:0] frac_i = '0;
    logic [2:0]        mode_i = '0;
    logic              sign_o;
    logic [INT_W-1:0]  mag_o;
    logic              inexact_o;
    logic              ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fxr_round_top #(.INT_W(INT_W), .FRAC_W(FRAC_W), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .int_i(int_i), .frac_i(frac_i),
        .mode_i(mode_i), .sign_o(sign_o), .mag_o(mag_o), .inexact_o(inexact_o), .ovf_o(ovf_o)
    );

    // expected {sign, mag, inexact, ovf}, from the requirement text
    function automatic logic [INT_W+2:0] model(input logic s, input int ip, input int fp, input int m);
        int up;
        int mag;
        int mm;
        mm = (m > 4) ? 0 : m;
        up = 0;
        case (mm)
            0: up = (fp > HALF) || (fp == HALF && (ip % 2) == 1);
            1: up = (fp > HALF) || (fp == HALF && !s);
            2: up = 0;
            3: up = (fp != 0) && !s;
            default: up = (fp != 0) && s;
        endcase
        mag = ip + up;
        model = {s, INT_W'(mag % (1 << INT_W)), fp != 0, mag == (1 << INT_W)};
    endfunction

    task automatic check(input string tag, input logic [INT_W+2:0] exp);
        checks++;
        if ({sign_o, mag_o, inexact_o, ovf_o} !== exp) begin
            errors++;
            $display("FAIL %s: got s=%0b m=%0d x=%0b v=%0b expected s=%0b m=%0d x=%0b v=%0b",
                     tag, sign_o, mag_o, inexact_o, ovf_o,
                     exp[INT_W+2], exp[INT_W+1:2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(input string tag, input logic s, input int ip, input int fp, input int m,
                         input int want_mag);
        logic [INT_W+2:0] exp;
        @(negedge clk);
        sign_i = s; int_i = INT_W'(ip); frac_i = FRAC_W'(fp); mode_i = 3'(m);
        @(posedge clk); #1;
        exp = model(s, ip, fp, m);
        if (want_mag >= 0 && int'(exp[INT_W+1:2]) != want_mag) begin
            checks++; errors++;
            $display("FAIL %s: model got m=%0d expected %0d", tag, exp[INT_W+1:2], want_mag);
        end
        check(tag, exp);
    endtask

    initial begin : wd
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        sign_i = 1'b1; int_i = 4'd9; frac_i = 3'd5; mode_i = 3'd3;
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset", '0);
        @(negedge clk); rst_n = 1'b1;

        apply("R1 +3.5", 0, 3, 4, 0, 4);
        apply("R1 +4.5", 0, 4, 4, 0, 4);
        apply("R1 -2.5", 1, 2, 4, 0, 2);
        apply("R2 below half", 0, 5, 3, 0, 5);
        apply("R2 above half", 1, 5, 5, 1, 6);
        apply("R3 +2.5", 0, 2, 4, 1, 3);
        apply("R3 -2.5", 1, 2, 4, 1, 2);
        apply("R4 +3.875", 0, 3, 7, 2, 3);
        apply("R10 -0.375 zero", 1, 0, 3, 2, 0);
        apply("R5 +1.125", 0, 1, 1, 3, 2);
        apply("R5 -1.125", 1, 1, 1, 3, 1);
        apply("R6 -1.125", 1, 1, 1, 4, 2);
        apply("R6 +1.125", 0, 1, 1, 4, 1);
        apply("R7 code5 +3.5", 0, 3, 4, 5, 4);
        apply("R7 code7 +4.5", 0, 4, 4, 7, 4);
        apply("R8 exact", 1, 6, 0, 3, 6);
        apply("R9 carry", 0, 15, 1, 3, 0);
        apply("R9 no carry", 1, 15, 1, 3, 15);

        // R11: output holds until the next rising edge
        @(negedge clk);
        sign_i = 1'b0; int_i = 4'd2; frac_i = 3'd6; mode_i = 3'd0;
        #1;
        check("R11 hold", {1'b1, 4'd15, 1'b1, 1'b0});
        @(posedge clk); #1;
        check("R11 update", {1'b0, 4'd3, 1'b1, 1'b0});

        // range -4..+4 in every mode
        for (int m = 0; m < 5; m++) begin
            for (int v = -32; v <= 32; v++) begin
                int a;
                a = (v < 0) ? -v : v;
                apply("R1 sweep", v < 0, a / 8, a % 8, m, -1);
            end
        end

        for (int k = 0; k < 400; k++) begin
            apply("R2 random", 1'($urandom), int'($urandom % 16), int'($urandom % 8),
                  int'($urandom % 8), -1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule